// File: doc/BRIEF.md
# Snooping Five-State Line Coherence Controller

This block tracks the coherence state of every line of one private, direct-mapped cache in a small multiprocessor whose caches share a common bus. Each line stores a tag and three state bits (valid, dirty, shared), which together encode five states: Modified, Owned, Exclusive, Shared and Invalid. The block resolves each local request and each probe from another cache in a single cycle. All outputs are combinational, and the state arrays update on the next rising clock edge.

On the local side the processor presents a read or a write. The block reports hit or miss, the bus command to issue, the line's next state, and any write-back of a dirty victim. On the snoop side the block observes a read or write probe from another cache. It reports whether it holds the line, whether it supplies the data in place of memory, the shared response, and the line's next state. The data storage, the memory, and arbitration between caches all lie outside the block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first local read of any address misses.
- R2: A local read miss issues bus command 1 (read). The line is filled as Exclusive (state bits v/d/s = 100) when `bus_shared_in` is low in that cycle, and as Shared (101) when it is high.
- R3: A local write miss issues bus command 2 (read-exclusive) and fills the line as Modified (110). A local request to the same address in the following cycle then hits, provided no probe arrives in that cycle.
- R4: A local write hit on an Exclusive (100) or Modified (110) line issues no bus command (0) and leaves the line Modified.
- R5: A local write hit on a Shared (101) or Owned (111) line issues bus command 3 (invalidate) and leaves the line Modified.
- R6: A local read hit issues no bus command and keeps the line's state.
- R7: A read probe that hits a Modified line moves it to Owned (111), asserts data supply and the shared response, and causes no write-back.
- R8: A read probe that hits an Owned line keeps it Owned and supplies data. A read probe that hits an Exclusive or Shared line moves it to Shared without supplying data. Every read-probe hit asserts the shared response.
- R9: A write probe that hits a line in any valid state moves it to Invalid (000). Data is supplied only if the line was Modified or Owned, and the shared response stays low.
- R10: A local miss whose victim is Modified or Owned raises `wb_valid`, with `wb_addr` set to the victim's tag and index. A victim in the Exclusive or Shared state is dropped with no write-back.
- R11: When a probe and a local request hit the same index in the same cycle, the probe is applied first and the local request sees the resulting state.
- R12: A probe that misses (invalid line or different tag) changes nothing and drives all snoop outputs low. With no request present, the outputs for that side are zero. An address splits into index = low `IDX_W` bits and tag = the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Local request valid |
| cpu_wr | input | 1 | Local request is a write |
| cpu_addr | input | ADDR_W | Local line address |
| bus_shared_in | input | 1 | Wired-OR shared indication from the other caches |
| snp_req | input | 1 | Probe valid |
| snp_wr | input | 1 | Probe is a write (invalidating) |
| snp_addr | input | ADDR_W | Probe line address |
| cpu_hit | output | 1 | Local request hit |
| cpu_nstate | output | 3 | Next state {v,d,s} of the local line |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 invalidate |
| bus_addr | output | ADDR_W | Address of bus_cmd, zero when none |
| wb_valid | output | 1 | Dirty victim write-back |
| wb_addr | output | ADDR_W | Victim address, zero when no write-back |
| snp_hit | output | 1 | Probe hit a valid line |
| snp_supply | output | 1 | This cache supplies the probed data |
| snp_shared | output | 1 | Shared response to a read probe |
| snp_nstate | output | 3 | Next state {v,d,s} of the probed line, zero on a miss |

## Verification
The bench first runs a directed walk through every state on one line. The walk separates the silent Exclusive upgrade from the Shared and Owned invalidate path, and the Modified-to-Owned probe transition from the Exclusive-to-Shared one. It also separates a dirty victim from a clean one. Constrained random traffic then uses three tags on four indices, so probes and local requests often collide on the same line in the same cycle. This is what exposes a wrong ordering between probe and local request. The random `bus_shared_in` values distinguish the Exclusive fill from the Shared fill.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef struct packed {
    logic v;
    logic d;
    logic s;
  } lstate_t;

  localparam lstate_t ST_I = 3'b000;
  localparam lstate_t ST_S = 3'b101;
  localparam lstate_t ST_E = 3'b100;
  localparam lstate_t ST_O = 3'b111;
  localparam lstate_t ST_M = 3'b110;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } buscmd_t;

  // State after a probe hit: writes kill the line, dirty lines become owner.
  function automatic lstate_t snoop_next(lstate_t cur, logic is_wr);
    if (!cur.v || is_wr) return ST_I;
    if (cur.d)           return ST_O;
    return ST_S;
  endfunction

  // State after a local access.
  function automatic lstate_t local_next(lstate_t cur, logic hit, logic is_wr, logic shr);
    if (is_wr) return ST_M;
    if (hit)   return cur;
    return shr ? ST_S : ST_E;
  endfunction

  // Bus command for a local access; s bit marks lines other caches may hold.
  function automatic buscmd_t local_cmd(lstate_t cur, logic hit, logic is_wr);
    if (!hit)          return is_wr ? BC_RDX : BC_RD;
    if (is_wr && cur.s) return BC_UPG;
    return BC_NONE;
  endfunction

endpackage

// File: rtl/moesi_tag_store.sv
module moesi_tag_store
  import moesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] loc_idx,
  output logic [TAG_W-1:0] snp_tag_q,
  output lstate_t          snp_st_q,
  output logic [TAG_W-1:0] loc_tag_q,
  output lstate_t          loc_st_q,
  input  logic             snp_we,
  input  lstate_t          snp_wst,
  input  logic             loc_we,
  input  logic [TAG_W-1:0] loc_wtag,
  input  lstate_t          loc_wst
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  lstate_t          st_q  [LINES];

  // Local write wins: its state was computed from the post-probe view.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (loc_we && loc_idx == IDX_W'(i)) begin
          tag_q[i] <= loc_wtag;
          st_q[i]  <= loc_wst;
        end else if (snp_we && snp_idx == IDX_W'(i)) begin
          st_q[i]  <= snp_wst;
        end
      end
    end
  end

  assign snp_tag_q = tag_q[snp_idx];
  assign snp_st_q  = st_q[snp_idx];
  assign loc_tag_q = tag_q[loc_idx];
  assign loc_st_q  = st_q[loc_idx];

endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             req,
  input  logic             wr,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] cur_tag,
  input  lstate_t          cur_st,
  output logic             hit,
  output logic             supply,
  output logic             shared_rsp,
  output lstate_t          nst
);
  always_comb begin
    hit        = req && cur_st.v && (cur_tag == tag);
    supply     = hit && cur_st.d;
    shared_rsp = hit && !wr;
    nst        = hit ? snoop_next(cur_st, wr) : ST_I;
  end
endmodule

// File: rtl/moesi_local_unit.sv
module moesi_local_unit
  import moesi_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             req,
  input  logic             wr,
  input  logic             shr_in,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] cur_tag,
  input  lstate_t          cur_st,
  output logic             hit,
  output buscmd_t          cmd,
  output lstate_t          nst,
  output logic             evict
);
  always_comb begin
    hit   = req && cur_st.v && (cur_tag == tag);
    cmd   = req ? local_cmd(cur_st, hit, wr) : BC_NONE;
    nst   = req ? local_next(cur_st, hit, wr, shr_in) : ST_I;
    evict = req && !hit && cur_st.v && cur_st.d;
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              bus_shared_in,
  input  logic              snp_req,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              cpu_hit,
  output logic [2:0]        cpu_nstate,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic              snp_shared,
  output logic [2:0]        snp_nstate
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] loc_idx, snp_idx;
  logic [TAG_W-1:0] loc_tag, snp_tag;
  assign loc_idx = cpu_addr[IDX_W-1:0];
  assign loc_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0] snp_tag_q, loc_tag_q;
  lstate_t          snp_st_q, loc_st_q;
  lstate_t          snp_nst, loc_nst, loc_view_st;
  logic             s_hit, s_sup, s_shr;
  logic             l_hit, l_evict;
  buscmd_t          l_cmd;
  logic             probe_first;

  moesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_idx   (snp_idx),
    .loc_idx   (loc_idx),
    .snp_tag_q (snp_tag_q),
    .snp_st_q  (snp_st_q),
    .loc_tag_q (loc_tag_q),
    .loc_st_q  (loc_st_q),
    .snp_we    (s_hit),
    .snp_wst   (snp_nst),
    .loc_we    (cpu_req),
    .loc_wtag  (loc_tag),
    .loc_wst   (loc_nst)
  );

  moesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .req        (snp_req),
    .wr         (snp_wr),
    .tag        (snp_tag),
    .cur_tag    (snp_tag_q),
    .cur_st     (snp_st_q),
    .hit        (s_hit),
    .supply     (s_sup),
    .shared_rsp (s_shr),
    .nst        (snp_nst)
  );

  // Probe is ordered ahead of the local request on the same line.
  assign probe_first = s_hit && (snp_idx == loc_idx);
  assign loc_view_st = probe_first ? snp_nst : loc_st_q;

  moesi_local_unit #(.TAG_W(TAG_W)) u_local (
    .req     (cpu_req),
    .wr      (cpu_wr),
    .shr_in  (bus_shared_in),
    .tag     (loc_tag),
    .cur_tag (loc_tag_q),
    .cur_st  (loc_view_st),
    .hit     (l_hit),
    .cmd     (l_cmd),
    .nst     (loc_nst),
    .evict   (l_evict)
  );

  assign cpu_hit    = l_hit;
  assign cpu_nstate = loc_nst;
  assign bus_cmd    = l_cmd;
  assign bus_addr   = (l_cmd != BC_NONE) ? cpu_addr : '0;
  assign wb_valid   = l_evict;
  assign wb_addr    = l_evict ? {loc_tag_q, loc_idx} : '0;
  assign snp_hit    = s_hit;
  assign snp_supply = s_sup;
  assign snp_shared = s_shr;
  assign snp_nstate = snp_nst;

  AST_READ_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_wr && !cpu_hit) |-> (bus_cmd == BC_RD && cpu_nstate[2] && !cpu_nstate[1])); // R2
  AST_WRITE_MISS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_wr && !cpu_hit) |-> (bus_cmd == BC_RDX && cpu_nstate == ST_M)); // R3
  AST_FILL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpu_req) && cpu_req && !snp_req && cpu_addr == $past(cpu_addr)) |-> cpu_hit); // R3
  AST_EXCL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_wr && cpu_hit && loc_view_st == ST_E) |-> (bus_cmd == BC_NONE && cpu_nstate == ST_M)); // R4
  AST_SHARED_WRITE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_wr && cpu_hit && loc_view_st.s) |-> (bus_cmd == BC_UPG)); // R5
  AST_MOD_PROBE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !snp_wr && snp_st_q == ST_M) |-> (snp_nstate == ST_O && snp_supply && snp_shared)); // R7
  AST_WR_PROBE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && snp_wr) |-> (snp_nstate == ST_I && !snp_shared)); // R9
  AST_CLEAN_VICTIM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_hit && !loc_view_st.d) |-> !wb_valid); // R10
  AST_PROBE_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_hit |-> (!snp_supply && !snp_shared && snp_nstate == ST_I)); // R12

endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  localparam int AW = 10;
  localparam int IW = 3;
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;

  typedef enum int {XI, XS, XE, XO, XM} mst_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic cpu_req, cpu_wr, bus_shared_in, snp_req, snp_wr;
  logic [AW-1:0] cpu_addr, snp_addr;
  logic cpu_hit, wb_valid, snp_hit, snp_supply, snp_shared;
  logic [2:0] cpu_nstate, snp_nstate;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr, wb_addr;

  moesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .bus_shared_in(bus_shared_in), .snp_req(snp_req), .snp_wr(snp_wr), .snp_addr(snp_addr),
    .cpu_hit(cpu_hit), .cpu_nstate(cpu_nstate), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .snp_hit(snp_hit), .snp_supply(snp_supply),
    .snp_shared(snp_shared), .snp_nstate(snp_nstate)
  );

  mst_t         m_st  [NL];
  logic [TW-1:0] m_tag [NL];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [2:0] enc(mst_t s);
    case (s)
      XM: return 3'b110;
      XO: return 3'b111;
      XE: return 3'b100;
      XS: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic owner(mst_t s);
    return (s == XM) || (s == XO);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input bit cr, input bit cw, input logic [AW-1:0] ca, input bit sh,
                       input bit sr, input bit sw, input logic [AW-1:0] sa, input string tag_ovr);
    int unsigned si, li;
    logic [TW-1:0] st, lt;
    mst_t s_cur, s_new, l_cur, l_new;
    bit s_hit, l_hit, l_wb;
    logic [1:0] cmd;
    string sl, ll;
    @(negedge clk);
    cpu_req = cr; cpu_wr = cw; cpu_addr = ca; bus_shared_in = sh;
    snp_req = sr; snp_wr = sw; snp_addr = sa;
    #1;
    // probe side first
    si = int'(sa[IW-1:0]); st = sa[AW-1:IW];
    s_cur = m_st[si];
    s_hit = sr && (s_cur != XI) && (m_tag[si] == st);
    if (!s_hit)      s_new = s_cur;
    else if (sw)     s_new = XI;
    else if (owner(s_cur)) s_new = XO;
    else             s_new = XS;
    sl = !s_hit ? "R12" : sw ? "R9" : (s_cur == XM) ? "R7" : "R8";
    check(sl, 64'({snp_hit, snp_supply, snp_shared, snp_nstate}),
          64'({s_hit, s_hit && owner(s_cur), s_hit && !sw, s_hit ? enc(s_new) : 3'b000}));
    if (s_hit) m_st[si] = s_new;
    // local side sees post-probe state
    li = int'(ca[IW-1:0]); lt = ca[AW-1:IW];
    l_cur = m_st[li];
    l_hit = cr && (l_cur != XI) && (m_tag[li] == lt);
    l_wb  = cr && !l_hit && owner(l_cur);
    if (!cr)        cmd = 2'd0;
    else if (!l_hit) cmd = cw ? 2'd2 : 2'd1;
    else if (cw && (l_cur == XS || l_cur == XO)) cmd = 2'd3;
    else            cmd = 2'd0;
    if (!cr)        l_new = XI;
    else if (cw)    l_new = XM;
    else if (l_hit) l_new = l_cur;
    else            l_new = sh ? XS : XE;
    if (tag_ovr != "")               ll = tag_ovr;
    else if (sr && si == li)         ll = "R11";
    else if (!cr)                    ll = "R12";
    else if (l_wb)                   ll = "R10";
    else if (!l_hit)                 ll = cw ? "R3" : "R2";
    else if (!cw)                    ll = "R6";
    else if (l_cur == XE || l_cur == XM) ll = "R4";
    else                             ll = "R5";
    check(ll, 64'({cpu_hit, cpu_nstate, bus_cmd, bus_addr, wb_valid, wb_addr}),
          64'({l_hit, enc(l_new), cmd, (cmd != 2'd0) ? ca : {AW{1'b0}},
               l_wb, l_wb ? {m_tag[li], li[IW-1:0]} : {AW{1'b0}}}));
    if (cr) begin
      m_tag[li] = lt;
      m_st[li]  = l_new;
    end
  endtask

  function automatic logic [AW-1:0] mk(int unsigned tg, int unsigned ix);
    return {TW'(tg), IW'(ix)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0C0D));
    rst_n = 1'b0;
    cpu_req = 0; cpu_wr = 0; cpu_addr = '0; bus_shared_in = 0;
    snp_req = 0; snp_wr = 0; snp_addr = '0;
    for (int i = 0; i < NL; i++) begin m_st[i] = XI; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // directed walk on one line, then neighbours
    apply(1, 0, mk(1, 1), 0, 0, 0, '0, "R1");  // R1 reset -> miss, R2 Exclusive fill
    apply(1, 0, mk(1, 1), 1, 0, 0, '0, "");    // R6 read hit keeps E
    apply(1, 1, mk(1, 1), 0, 0, 0, '0, "");    // R4 silent E->M
    apply(0, 0, '0, 0, 1, 0, mk(1, 1), "");    // R7 M->O with supply
    apply(0, 0, '0, 0, 1, 0, mk(1, 1), "");    // R8 O stays O
    apply(1, 1, mk(1, 1), 0, 0, 0, '0, "");    // R5 O write -> invalidate
    apply(0, 0, '0, 0, 1, 1, mk(1, 1), "");    // R9 write probe kills dirty line
    apply(1, 0, mk(1, 1), 1, 0, 0, '0, "");    // R2 shared fill
    apply(0, 0, '0, 0, 1, 0, mk(1, 1), "");    // R8 S stays S, no supply
    apply(1, 1, mk(2, 1), 0, 0, 0, '0, "");    // R3 write miss, R10 clean victim silent
    apply(1, 0, mk(1, 1), 0, 0, 0, '0, "");    // R10 dirty victim write-back
    apply(1, 0, mk(1, 1), 0, 1, 1, mk(1, 1), ""); // R11 probe kills first, local misses
    apply(0, 0, '0, 0, 1, 1, mk(3, 1), "");    // R12 probe of other tag ignored
    apply(1, 0, mk(1, 1), 0, 0, 0, '0, "");    // R12 line survived the probe
    apply(0, 0, '0, 0, 0, 0, '0, "");          // R12 idle
    for (int n = 0; n < 3000; n++) begin
      bit cr, cw, sh, sr, sw;
      cr = ($urandom % 10) < 7;
      cw = $urandom % 2;
      sh = $urandom % 2;
      sr = ($urandom % 10) < 4;
      sw = $urandom % 2;
      apply(cr, cw, mk($urandom % 3, $urandom % 4), sh,
            sr, sw, mk($urandom % 3, $urandom % 4), "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule